// File: doc/BRIEF.md
# Section Trace Identifier Monitor

This block watches the section trace byte that a framer pulls out of each incoming frame. One byte comes in per frame, on a valid/ready stream. The block groups the bytes into trace messages in the format that software selects. A message is accepted only after enough identical copies arrive in a row. On the 16-byte format it also checks an embedded CRC-7. The accepted message is then compared with an expected trace that software has programmed.

The block keeps three alarm states: unstable, mismatch and CRC error. Two configuration bits make the mismatch alarm depend on the other two. Every change of an alarm, in either direction, is latched into a status bit. A read strobe clears these bits, and a per-bit enable drives them onto one interrupt line.

The stream never applies back-pressure. `in_ready` is held high, and a byte is taken in every cycle where `in_valid` is high. One frame strobe is therefore one valid cycle.

Top module: `sec_trace_mon`

## Requirements
- R1: After reset the format select is 3'b010 (trace ignored), the stability select is 0, all three alarms are low, the status bits are 0, `irq` is low and `in_ready` is high.
- R2: With `fmt_sel` equal to 3'b01x, incoming bytes are ignored and all three alarms stay low.
- R3: With `fmt_sel` equal to 3'b00x, every byte is a complete message. With `stab_long`=0, the unstable alarm clears on the 3rd identical message in a row and is high before that.
- R4: With `stab_long`=1, five identical messages in a row are needed to clear the unstable alarm.
- R5: A message that differs from the one before it raises the unstable alarm and restarts the count of identical messages at one.
- R6: Once a message is accepted, the mismatch alarm shows whether it differs from the expected trace written through `exp_we`/`exp_addr`/`exp_wdata`. Expected byte i pairs with message byte i. While the trace is unstable, the last result is held.
- R7: With `fmt_sel` equal to 3'b10x, a message is 16 bytes long and starts at a byte whose bit 7 is 1. The low 7 bits of that byte carry a CRC-7 (polynomial x^7+x^3+1, MSB first, initial value 0) computed over all 16 bytes with those 7 bits taken as zero. The CRC alarm follows the result of the latest message.
- R8: With `fmt_sel`=3'b111, a message is 64 bytes long and starts at the byte after a carriage return (8'h0D) followed by a linefeed (8'h0A). Bytes that arrive before the first such pair are ignored.
- R9: With `fmt_sel`=3'b110, a message is a 64-byte window counted from the cycle the format was selected. It is never realigned.
- R10: When `force_unstable`=1 and the unstable alarm is high, the mismatch alarm is high. With the bit at 0, the two alarms are independent.
- R11: When `mask_on_crc`=1 and the CRC alarm is high, the mismatch alarm is low, unless R10 forces it high.
- R12: `irq_stat` bit 0 (unstable), bit 1 (mismatch) and bit 2 (CRC) sets on any change of its alarm and clears one cycle after `stat_rd`. `irq` is the OR of the status bits that are enabled in `irq_en`, which uses the same bit positions.
- R13: When an alarm change and `stat_rd` fall in the same cycle, the status bit for that change stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Trace byte valid, one per frame |
| in_ready | output | 1 | Always high, no back-pressure |
| in_data | input | 8 | Trace byte |
| fmt_sel | input | 3 | Trace format code |
| stab_long | input | 1 | 1: five identical messages, 0: three |
| force_unstable | input | 1 | Unstable alarm forces mismatch |
| mask_on_crc | input | 1 | CRC alarm suppresses mismatch |
| exp_we | input | 1 | Expected-trace write strobe |
| exp_addr | input | 6 | Expected-trace byte index |
| exp_wdata | input | 8 | Expected-trace byte |
| irq_en | input | 3 | Per-alarm interrupt enable |
| stat_rd | input | 1 | Status read strobe, clears the latched bits |
| alarm_unstable | output | 1 | Trace unstable alarm |
| alarm_mismatch | output | 1 | Trace mismatch alarm |
| alarm_crc | output | 1 | CRC-7 error alarm |
| irq_stat | output | 3 | Latched change bits |
| irq | output | 1 | Shared interrupt |

## Verification
Two functions can land in the same cycle: a status read and a new alarm change. The bench sends the byte that completes the third identical message. It counts the two register stages to the moment the unstable alarm falls, then pulses `stat_rd` in exactly the cycle the status register captures that change. The bit must still read 1 afterwards. Configuration changes that act while a message is in flight, such as a format switch, also land next to message completions. They are judged from the alarm levels once the change has settled.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [2:0] {
    MODE_OFF, MODE_ONE, MODE_CRC, MODE_FREE, MODE_FRAMED
  } mode_e;

  localparam logic [7:0] CHR_CR = 8'h0D;
  localparam logic [7:0] CHR_LF = 8'h0A;

  function automatic mode_e decode_fmt(input logic [2:0] f);
    mode_e m;
    casez (f)
      3'b111:  m = MODE_FRAMED;
      3'b110:  m = MODE_FREE;
      3'b10?:  m = MODE_CRC;
      3'b01?:  m = MODE_OFF;
      default: m = MODE_ONE;
    endcase
    return m;
  endfunction

  // CRC-7, x^7 + x^3 + 1, MSB first
  function automatic logic [6:0] crc7_byte(input logic [6:0] c_in, input logic [7:0] d);
    logic [6:0] c;
    logic fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[6] ^ d[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction
endpackage

// File: rtl/trc_assembler.sv
module trc_assembler
  import trc_pkg::*;
#(
  parameter int LONG_LEN  = 64,
  parameter int SHORT_LEN = 16,
  parameter int IDX_W     = $clog2(LONG_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic             restart,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             exp_we,
  input  logic [IDX_W-1:0] exp_addr,
  input  logic [7:0]       exp_wdata,
  output logic             done_o,
  output logic             same_o,
  output logic             mism_o,
  output logic             crcbad_o
);
  logic [7:0] last_mem [LONG_LEN];
  logic [7:0] exp_mem  [LONG_LEN];

  logic [IDX_W-1:0] idx, pos, len_m1;
  logic       synced, align, take, first, fin;
  logic [7:0] prev1, prev2, db;
  logic       diff_r, mm_r, diff_n, mm_n;
  logic [6:0] crc_r, rxc_r, crc_n, rxc_n;

  always_comb begin
    unique case (mode)
      MODE_ONE:    begin align = 1'b1;      len_m1 = '0; end
      MODE_CRC:    begin align = in_data[7]; len_m1 = IDX_W'(SHORT_LEN - 1); end
      MODE_FRAMED: begin align = (prev2 == CHR_CR) && (prev1 == CHR_LF);
                         len_m1 = IDX_W'(LONG_LEN - 1); end
      default:     begin align = 1'b0;      len_m1 = IDX_W'(LONG_LEN - 1); end
    endcase
    take   = in_valid && (mode != MODE_OFF) && !restart
             && (align || synced || mode == MODE_FREE);
    pos    = align ? '0 : idx;
    first  = (pos == '0);
    fin    = (pos == len_m1);
    diff_n = (first ? 1'b0 : diff_r) | (in_data != last_mem[pos]);
    mm_n   = (first ? 1'b0 : mm_r)   | (in_data != exp_mem[pos]);
    db     = (mode == MODE_CRC && first) ? {in_data[7], 7'b0} : in_data;
    crc_n  = crc7_byte(first ? 7'd0 : crc_r, db);
    rxc_n  = first ? in_data[6:0] : rxc_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; synced <= 1'b0; prev1 <= '0; prev2 <= '0;
      diff_r <= 1'b0; mm_r <= 1'b0; crc_r <= '0; rxc_r <= '0;
      done_o <= 1'b0; same_o <= 1'b0; mism_o <= 1'b0; crcbad_o <= 1'b0;
    end else begin
      if (in_valid) begin
        prev2 <= prev1;
        prev1 <= in_data;
      end
      done_o <= take && fin;
      if (restart || mode == MODE_OFF) begin
        idx <= '0;
        synced <= 1'b0;
      end else if (take) begin
        idx    <= fin ? '0 : pos + 1'b1;
        synced <= 1'b1;
        diff_r <= diff_n;
        mm_r   <= mm_n;
        crc_r  <= crc_n;
        rxc_r  <= rxc_n;
        same_o   <= !diff_n;
        mism_o   <= mm_n;
        crcbad_o <= (crc_n != rxc_n);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) last_mem[pos] <= in_data;
    if (exp_we) exp_mem[exp_addr] <= exp_wdata;
  end

  // R3: a completed message needs a byte taken the cycle before
  assert_done_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(in_valid));
endmodule

// File: rtl/trc_alarm.sv
module trc_alarm #(
  parameter int STAB_LO = 3,
  parameter int STAB_HI = 5,
  parameter int CNT_W   = $clog2(STAB_HI + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  input  logic is_crc,
  input  logic done,
  input  logic same,
  input  logic mism,
  input  logic crcbad,
  input  logic stab_long,
  input  logic force_unst,
  input  logic crc_mask,
  output logic unstable_o,
  output logic mismatch_o,
  output logic crcerr_o
);
  logic [CNT_W-1:0] cnt, cnt_n, need;
  logic crc_r, mm_r;

  always_comb begin
    need = stab_long ? CNT_W'(STAB_HI) : CNT_W'(STAB_LO);
    if (cnt == '0 || !same)          cnt_n = CNT_W'(1);
    else if (cnt == CNT_W'(STAB_HI)) cnt_n = cnt;
    else                             cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !active) begin
      cnt <= '0; crc_r <= 1'b0; mm_r <= 1'b0;
    end else if (done) begin
      cnt   <= cnt_n;
      crc_r <= is_crc && crcbad;
      if (cnt_n >= need) mm_r <= mism;
    end
  end

  always_comb begin
    unstable_o = active && (cnt < need);
    crcerr_o   = active && crc_r;
    if (!active)                          mismatch_o = 1'b0;
    else if (force_unst && unstable_o)    mismatch_o = 1'b1;
    else if (crc_mask && crcerr_o)        mismatch_o = 1'b0;
    else                                  mismatch_o = mm_r;
  end

  // R5: a differing message leaves the trace unstable in the next cycle
  assert_diff_unstable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !same && active && !restart) |=> (unstable_o || !active));

  // R3: the unstable alarm clears only when a message completes
  assert_clear_on_msg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(unstable_o) && active && $past(active) && $stable(stab_long)) |-> $past(done));
endmodule

// File: rtl/trc_irq.sv
module trc_irq #(
  parameter int N_ALM = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ALM-1:0] alarms,
  input  logic             rd,
  input  logic [N_ALM-1:0] en,
  output logic [N_ALM-1:0] stat,
  output logic             irq
);
  logic [N_ALM-1:0] alarm_q, ev;

  assign ev  = alarms ^ alarm_q;
  assign irq = |(stat & en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= '0;
      stat    <= '0;
    end else begin
      alarm_q <= alarms;
      stat    <= ev | (stat & {N_ALM{~rd}});
    end
  end

  // R13: a change seen in a read cycle is not lost
  assert_event_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((stat & $past(ev)) == $past(ev)));

  // R12: a read with no change clears every bit
  assert_read_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> ((stat & ~$past(ev)) == '0));
endmodule

// File: rtl/sec_trace_mon.sv
module sec_trace_mon
  import trc_pkg::*;
#(
  parameter int LONG_LEN  = 64,
  parameter int SHORT_LEN = 16,
  parameter int IDX_W     = $clog2(LONG_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic [2:0]       fmt_sel,
  input  logic             stab_long,
  input  logic             force_unstable,
  input  logic             mask_on_crc,
  input  logic             exp_we,
  input  logic [IDX_W-1:0] exp_addr,
  input  logic [7:0]       exp_wdata,
  input  logic [2:0]       irq_en,
  input  logic             stat_rd,
  output logic             alarm_unstable,
  output logic             alarm_mismatch,
  output logic             alarm_crc,
  output logic [2:0]       irq_stat,
  output logic             irq
);
  logic [2:0] fmt_q;
  mode_e      mode;
  logic       restart, active;
  logic       done, same, mism, crcbad;

  assign in_ready = 1'b1;
  assign mode     = decode_fmt(fmt_sel);
  assign active   = (mode != MODE_OFF);
  assign restart  = (fmt_sel != fmt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) fmt_q <= 3'b010;
    else        fmt_q <= fmt_sel;
  end

  trc_assembler #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN), .IDX_W(IDX_W)) asm_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .restart(restart),
    .in_valid(in_valid), .in_data(in_data),
    .exp_we(exp_we), .exp_addr(exp_addr), .exp_wdata(exp_wdata),
    .done_o(done), .same_o(same), .mism_o(mism), .crcbad_o(crcbad)
  );

  trc_alarm alm_i (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(restart),
    .is_crc(mode == MODE_CRC), .done(done), .same(same), .mism(mism),
    .crcbad(crcbad), .stab_long(stab_long), .force_unst(force_unstable),
    .crc_mask(mask_on_crc), .unstable_o(alarm_unstable),
    .mismatch_o(alarm_mismatch), .crcerr_o(alarm_crc)
  );

  trc_irq #(.N_ALM(3)) irq_i (
    .clk(clk), .rst_n(rst_n),
    .alarms({alarm_crc, alarm_mismatch, alarm_unstable}),
    .rd(stat_rd), .en(irq_en), .stat(irq_stat), .irq(irq)
  );

  // R2: an ignored trace raises no alarm
  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel[2:1] == 2'b01) |-> !(alarm_unstable || alarm_mismatch || alarm_crc));
endmodule

// File: tb/sec_trace_mon_tb_top.sv
module sec_trace_mon_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic [2:0] fmt_sel = 3'b010;
  logic stab_long = 0, force_unstable = 0, mask_on_crc = 0;
  logic exp_we = 0;
  logic [5:0] exp_addr = '0;
  logic [7:0] exp_wdata = '0;
  logic [2:0] irq_en = '0;
  logic stat_rd = 0;
  logic alarm_unstable, alarm_mismatch, alarm_crc, irq;
  logic [2:0] irq_stat;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] m16 [16];
  logic [7:0] m64 [64];

  always #4 clk = ~clk;

  sec_trace_mon dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .fmt_sel(fmt_sel), .stab_long(stab_long),
    .force_unstable(force_unstable), .mask_on_crc(mask_on_crc),
    .exp_we(exp_we), .exp_addr(exp_addr), .exp_wdata(exp_wdata),
    .irq_en(irq_en), .stat_rd(stat_rd), .alarm_unstable(alarm_unstable),
    .alarm_mismatch(alarm_mismatch), .alarm_crc(alarm_crc),
    .irq_stat(irq_stat), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic wr_exp(input int a, input logic [7:0] d);
    exp_we = 1'b1; exp_addr = 6'(a); exp_wdata = d;
    @(negedge clk);
    exp_we = 1'b0;
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic set_fmt(input logic [2:0] f);
    fmt_sel = f;
    settle();
  endtask

  function automatic logic [6:0] ref_crc(input logic [7:0] msg [16]);
    logic [6:0] c = '0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b = (i == 0) ? (msg[i] & 8'h80) : msg[i];
      for (int k = 7; k >= 0; k--) begin
        logic fb = c[6] ^ b[k];
        c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
    end
    return c;
  endfunction

  task automatic send16(input logic [7:0] first);
    send(first);
    for (int i = 1; i < 16; i++) send(m16[i]);
  endtask

  task automatic send64();
    for (int i = 0; i < 64; i++) send(m64[i]);
  endtask

  task automatic t_reset();
    chk("R1 unstable", alarm_unstable, 0);
    chk("R1 mismatch", alarm_mismatch, 0);
    chk("R1 crc", alarm_crc, 0);
    chk("R1 stat", irq_stat, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ready", in_ready, 1);
  endtask

  task automatic t_off();
    for (int i = 0; i < 6; i++) send(8'h41);
    settle();
    chk("R2 unstable", alarm_unstable, 0);
    chk("R2 mismatch|crc", {alarm_mismatch, alarm_crc}, 0);
  endtask

  task automatic t_single();
    wr_exp(0, 8'h41);
    set_fmt(3'b000);
    chk("R3 unstable before msgs", alarm_unstable, 1);
    send(8'h41); send(8'h41); settle();
    chk("R3 two copies", alarm_unstable, 1);
    send(8'h41); settle();
    chk("R3 three copies", alarm_unstable, 0);
    chk("R6 match", alarm_mismatch, 0);
    send(8'h42); settle();
    chk("R5 change", alarm_unstable, 1);
    chk("R6 held while unstable", alarm_mismatch, 0);
    send(8'h42); send(8'h42); settle();
    chk("R5 recount", alarm_unstable, 0);
    chk("R6 differs", alarm_mismatch, 1);
    stab_long = 1'b1;
    for (int i = 0; i < 4; i++) send(8'h41);
    settle();
    chk("R4 four copies", alarm_unstable, 1);
    send(8'h41); settle();
    chk("R4 five copies", alarm_unstable, 0);
    chk("R6 match again", alarm_mismatch, 0);
    stab_long = 1'b0;
  endtask

  task automatic t_force();
    force_unstable = 1'b1;
    send(8'h42); settle();
    chk("R10 unstable", alarm_unstable, 1);
    chk("R10 forced", alarm_mismatch, 1);
    force_unstable = 1'b0; settle();
    chk("R10 independent", alarm_mismatch, 0);
  endtask

  task automatic t_crc();
    logic [6:0] c;
    for (int i = 1; i < 16; i++) m16[i] = 8'h41 + 8'(i);
    m16[0] = 8'h80;
    c = ref_crc(m16);
    m16[0] = {1'b1, c};
    for (int i = 0; i < 16; i++) wr_exp(i, m16[i]);
    set_fmt(3'b100);
    send(8'h30);
    for (int n = 0; n < 3; n++) send16(m16[0]);
    settle();
    chk("R7 stable", alarm_unstable, 0);
    chk("R7 crc good", alarm_crc, 0);
    chk("R7 match", alarm_mismatch, 0);
    send16(m16[0] ^ 8'h01); settle();
    chk("R7 crc bad", alarm_crc, 1);
    chk("R7 unstable", alarm_unstable, 1);
    send16(m16[0] ^ 8'h01); send16(m16[0] ^ 8'h01); settle();
    chk("R11 unmasked", alarm_mismatch, 1);
    mask_on_crc = 1'b1; settle();
    chk("R11 masked", alarm_mismatch, 0);
    force_unstable = 1'b1; settle();
    chk("R11 masked with force, stable", alarm_mismatch, 0);
    send16(m16[0]); settle();
    chk("R7 crc recovers", alarm_crc, 0);
    chk("R10 force over mask", alarm_mismatch, 1);
    force_unstable = 1'b0; mask_on_crc = 1'b0;
  endtask

  task automatic t_framed();
    for (int i = 0; i < 62; i++) m64[i] = 8'h20 + 8'(i);
    m64[62] = 8'h0D; m64[63] = 8'h0A;
    for (int i = 0; i < 64; i++) wr_exp(i, m64[i]);
    set_fmt(3'b111);
    send(8'h0D); send(8'h0A);
    for (int n = 0; n < 3; n++) send64();
    settle();
    chk("R8 stable", alarm_unstable, 0);
    chk("R8 match", alarm_mismatch, 0);
    for (int i = 0; i < 5; i++) send(8'h7A);
    send64(); settle();
    chk("R8 misaligned", alarm_unstable, 1);
    for (int n = 0; n < 3; n++) send64();
    settle();
    chk("R8 realigned", alarm_unstable, 0);
  endtask

  task automatic t_free();
    set_fmt(3'b110);
    for (int n = 0; n < 3; n++) send64();
    settle();
    chk("R9 stable", alarm_unstable, 0);
    chk("R9 match", alarm_mismatch, 0);
    send(8'h55);
    for (int n = 0; n < 3; n++) send64();
    settle();
    chk("R9 no realign", alarm_unstable, 1);
  endtask

  task automatic t_irq();
    set_fmt(3'b010);
    rd_stat(); @(negedge clk);
    chk("R12 read clears", irq_stat, 0);
    set_fmt(3'b000);
    chk("R12 rise sets", irq_stat[0], 1);
    chk("R12 masked", irq, 0);
    irq_en = 3'b001; @(negedge clk);
    chk("R12 enabled", irq, 1);
    send(8'h41); send(8'h41); settle();
    rd_stat(); @(negedge clk);
    chk("R12 cleared", irq_stat[0], 0);
    in_valid = 1'b1; in_data = 8'h41;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    stat_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    stat_rd = 1'b0;
    chk("R13 event beats read", irq_stat[0], 1);
    chk("R12 fall", alarm_unstable, 0);
    irq_en = 3'b000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off();
    t_single();
    t_force();
    t_crc();
    t_framed();
    t_free();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule